// File: doc/BRIEF.md
# Sampled Performance Counter Bank

This block collects event statistics for one clock domain without disturbing the logic it observes. It holds a set of counter slots of two kinds. An accumulating slot adds a narrow unsigned event value into a 64-bit total on every cycle. A direct-capture slot records the present value of a wider target signal. A free-running cycle counter sits beside them as slot 0. The event inputs are forced to zero while the observed logic is held in its own reset or a chip-wide reset condition is raised. The cycle counter keeps counting through both.

At a programmable interval, every slot is copied on one clock edge into a bank of snapshot registers. A flag then tells the host that a fresh set is waiting. The host reads each 64-bit value as two 32-bit words and then writes the status register to release the bank for the next capture. The interval is given in base-domain cycles. The block divides it by its fixed clock ratio, dropping any remainder, to get its own local interval.

Top module: `perf_sample_bank`

## Requirements
- R1: On each cycle with neither reset input high, accumulating slot i adds the zero-extended event field `acc_ev[i*ACC_EVW +: ACC_EVW]` to its 64-bit total. The total wraps modulo 2^64.
- R2: At each capture, a direct-capture slot stores its input field `idn_val[j*IDN_W +: IDN_W]`, zero-extended to 64 bits.
- R3: The cycle counter (slot 0) advances by one on every cycle after `rst_n` rises, including cycles in which `tgt_rst` or `glb_rst` is high.
- R4: While `tgt_rst` or `glb_rst` is high, the accumulating totals hold their value, and a direct-capture slot captured in that state reads as zero.
- R5: With a local interval of zero, no capture takes place and the valid flag stays low. This covers a rate register of 0, and any rate below `CLK_RATIO`.
- R6: The local interval is floor(rate / `CLK_RATIO`). When the host clears the flag within the interval, successive captures lie exactly that many cycles apart.
- R7: A capture sets the valid flag. While the flag is set, the snapshot bank is frozen and further captures are held off. Writing 1 to bit 0 of address 0 clears the flag, and a held-off capture then occurs on the next cycle.
- R8: Register map (word addresses): address 0 reads `{31'b0, valid}`; address 1 is the 32-bit rate register. Slot s has its low word at address 2+2s and its high word at address 3+2s. Slot 0 is the cycle counter, slots 1..N_ACC are the accumulators, and the following slots are the direct-capture slots. After `rst_n`, all registers read zero.
- R9: All slots in one snapshot are taken on the same edge. An accumulator fed a constant event value v from reset onward, with no masking, reads v times the captured cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local domain clock |
| rst_n | input | 1 | Active-low reset of the counter bank itself |
| tgt_rst | input | 1 | Reset of the observed logic; masks events |
| glb_rst | input | 1 | Chip-wide reset condition; masks events |
| acc_ev | input | N_ACC*ACC_EVW | Packed event values, one field per accumulating slot |
| idn_val | input | N_IDN*IDN_W | Packed values, one field per direct-capture slot |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| snap_valid | output | 1 | A snapshot is waiting to be read |

## Verification
The assertions assume that `rst_n` stays low until the first clock edges have passed. They also assume the host never writes the rate register in the same cycle as a status clear, so each control write has a single effect per cycle. The bench changes inputs only on falling edges and issues one register write at a time, each lasting exactly one cycle. It raises `tgt_rst` and `glb_rst` only at whole-interval boundaries. As a result, each capture window is either fully masked or fully unmasked, and a delta between two snapshots has one exact expected value.

// File: rtl/perf_sample_bank.sv
module perf_sample_bank #(
  parameter int N_ACC     = 2,
  parameter int ACC_EVW   = 2,
  parameter int N_IDN     = 1,
  parameter int IDN_W     = 48,
  parameter int CLK_RATIO = 2,
  localparam int SLOTS    = 1 + N_ACC + N_IDN,
  localparam int NREG     = 2 + 2 * SLOTS,
  localparam int AW       = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tgt_rst,
  input  logic                     glb_rst,
  input  logic [N_ACC*ACC_EVW-1:0] acc_ev,
  input  logic [N_IDN*IDN_W-1:0]   idn_val,
  input  logic                     reg_wr,
  input  logic [AW-1:0]            reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic                     snap_valid
);
  logic [63:0]             cyc_q;
  logic [N_ACC-1:0][63:0]  acc_q;
  logic [SLOTS-1:0][63:0]  live;
  logic [SLOTS-1:0][63:0]  snap_q;
  logic [31:0]             rate_q, tcnt_q, intv;
  logic                    valid_q, mask, tick, rate_wr, clr;
  logic [AW-1:0]           woff;
  logic [AW-2:0]           sidx;

  assign mask    = tgt_rst | glb_rst;
  assign intv    = rate_q / 32'(CLK_RATIO);
  assign tick    = (intv != 32'd0) && (tcnt_q >= intv - 32'd1);
  assign rate_wr = reg_wr && reg_addr == AW'(1);
  assign clr     = reg_wr && reg_addr == AW'(0) && reg_wdata[0];

  assign live[0] = cyc_q;
  for (genvar i = 0; i < N_ACC; i++) begin : g_acc_live
    assign live[1+i] = acc_q[i];
  end
  for (genvar j = 0; j < N_IDN; j++) begin : g_idn_live
    assign live[1+N_ACC+j] = mask ? 64'd0 : 64'(idn_val[j*IDN_W +: IDN_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      acc_q   <= '0;
      snap_q  <= '0;
      rate_q  <= '0;
      tcnt_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      cyc_q <= cyc_q + 64'd1;
      for (int i = 0; i < N_ACC; i++)
        acc_q[i] <= acc_q[i] + (mask ? 64'd0 : 64'(acc_ev[i*ACC_EVW +: ACC_EVW]));
      if (rate_wr) begin
        rate_q <= reg_wdata;
        tcnt_q <= '0;
      end else if (tick) begin
        if (!valid_q) tcnt_q <= '0;
      end else if (intv != 32'd0) begin
        tcnt_q <= tcnt_q + 32'd1;
      end
      if (tick && !valid_q) begin
        snap_q  <= live;
        valid_q <= 1'b1;
      end else if (clr) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign woff = reg_addr - AW'(2);
  assign sidx = woff[AW-1:1];

  always_comb begin
    reg_rdata = 32'd0;
    if (reg_addr == AW'(0))
      reg_rdata = {31'd0, valid_q};
    else if (reg_addr == AW'(1))
      reg_rdata = rate_q;
    else if (int'(sidx) < SLOTS)
      reg_rdata = woff[0] ? snap_q[sidx][63:32] : snap_q[sidx][31:0];
  end

  assign snap_valid = valid_q;
endmodule

module perf_sample_bank_chk #(
  parameter int N_ACC = 2,
  parameter int SLOTS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mask,
  input logic                    clr,
  input logic                    rate_wr,
  input logic [31:0]             intv,
  input logic                    valid_q,
  input logic [63:0]             cyc_q,
  input logic [N_ACC-1:0][63:0]  acc_q,
  input logic [SLOTS-1:0][63:0]  snap_q
);
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cyc_q == $past(cyc_q) + 64'd1); // R3

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> acc_q == $past(acc_q)); // R4

  AST_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (intv == 32'd0 && !valid_q) |=> !valid_q); // R5

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr) |=> (valid_q && $stable(snap_q))); // R7

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && clr && !rate_wr) |=> !valid_q); // R7
endmodule

bind perf_sample_bank perf_sample_bank_chk #(.N_ACC(N_ACC), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask(mask), .clr(clr), .rate_wr(rate_wr),
  .intv(intv), .valid_q(valid_q), .cyc_q(cyc_q), .acc_q(acc_q), .snap_q(snap_q)
);

// File: tb/tb_perf_sample_bank.sv
module tb_perf_sample_bank;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam logic [47:0] IDV = 48'h1234_89AB_CDEF;

  logic clk = 1'b0, rst_n = 1'b0, tgt_rst = 1'b0, glb_rst = 1'b0;
  logic [3:0]  acc_ev = {2'd3, 2'd1};
  logic [47:0] idn_val = IDV;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic snap_valid;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [63:0] s_cyc, s_a0, s_a1, s_id;
  logic [63:0] p_cyc, p_a0, p_a1;

  perf_sample_bank #(.N_ACC(2), .ACC_EVW(2), .N_IDN(1), .IDN_W(48), .CLK_RATIO(2)) dut (
    .clk(clk), .rst_n(rst_n), .tgt_rst(tgt_rst), .glb_rst(glb_rst),
    .acc_ev(acc_ev), .idn_val(idn_val), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snap_valid(snap_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = AW'(a);
    #1 v = reg_rdata;
  endtask

  task automatic rd64(input int slot, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(2 + 2*slot, lo);
    rd(3 + 2*slot, hi);
    v = {hi, lo};
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic grab(input bit do_clear);
    p_cyc = s_cyc; p_a0 = s_a0; p_a1 = s_a1;
    while (!snap_valid) @(negedge clk);
    rd64(0, s_cyc); rd64(1, s_a0); rd64(2, s_a1); rd64(3, s_id);
    if (do_clear) wr(0, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); check("R8 status after reset", v, 0);
    rd(1, v); check("R8 rate after reset", v, 0);
    rd(2, v); check("R8 slot0 low after reset", v, 0);
  endtask

  task automatic t_sync;
    logic [31:0] lo, hi;
    wr(1, 32'd20);
    grab(1'b0);
    check("R9 acc0 equals cycle count", s_a0, s_cyc);
    check("R9 acc1 equals 3x cycle count", s_a1, 3 * s_cyc);
    check("R2 identity captured", s_id, 64'(IDV));
    rd(8, lo); rd(9, hi);
    check("R8 identity low word", 64'(lo), 64'h89AB_CDEF);
    check("R8 identity high word", 64'(hi), 64'h1234);
    wr(0, 32'd1);
  endtask

  task automatic t_period;
    grab(1'b1); grab(1'b1);
    check("R6 cycle delta rate20", s_cyc - p_cyc, 10);
    check("R1 acc0 delta", s_a0 - p_a0, 10);
    check("R1 acc1 delta", s_a1 - p_a1, 30);
  endtask

  task automatic t_trunc;
    logic [31:0] v;
    wr(1, 32'd21);
    rd(1, v); check("R8 rate readback", v, 21);
    grab(1'b1); grab(1'b1); grab(1'b1);
    check("R6 truncated interval", s_cyc - p_cyc, 10);
  endtask

  task automatic t_mask;
    tgt_rst = 1'b1;
    grab(1'b1); grab(1'b0);
    check("R4 acc0 frozen in target reset", s_a0 - p_a0, 0);
    check("R4 acc1 frozen in target reset", s_a1 - p_a1, 0);
    check("R4 identity zero in target reset", s_id, 0);
    check("R3 cycles counted in target reset", s_cyc - p_cyc, 10);
    tgt_rst = 1'b0; glb_rst = 1'b1;
    wr(0, 32'd1);
    grab(1'b1); grab(1'b0);
    check("R4 acc0 frozen in global reset", s_a0 - p_a0, 0);
    check("R4 identity zero in global reset", s_id, 0);
    glb_rst = 1'b0;
    wr(0, 32'd1);
    grab(1'b1); grab(1'b1);
    check("R1 counting resumes", s_a1 - p_a1, 30);
    check("R2 identity after mask", s_id, 64'(IDV));
  endtask

  task automatic t_hold;
    logic [63:0] c;
    grab(1'b0);
    repeat (35) @(negedge clk);
    check("R7 flag held without clear", 64'(snap_valid), 1);
    rd64(0, c);
    check("R7 snapshot frozen", c, s_cyc);
    wr(0, 32'd1);
    @(negedge clk);
    check("R7 held-off capture after clear", 64'(snap_valid), 1);
  endtask

  task automatic t_disable;
    wr(1, 32'd1);
    wr(0, 32'd1);
    repeat (50) @(negedge clk);
    check("R5 rate below ratio disables", 64'(snap_valid), 0);
    wr(1, 32'd0);
    repeat (50) @(negedge clk);
    check("R5 rate zero disables", 64'(snap_valid), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_sync;
    t_period;
    t_trunc;
    t_mask;
    t_hold;
    t_disable;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule